// File: doc/BRIEF.md
# Quad SPI Programmable Sequence Engine

This block reads from a serial NOR flash by interpreting a short program of 16-bit instructions kept in a small table, rather than following a fixed command flow. Software loads the table through a word-wide write port and then fires a start pulse with a 24-bit flash address. The engine pulls chip select low and steps through the table. It shifts out command and address bits, idles for dummy clocks and gathers read bytes. It stops when it reaches a jump or stop instruction.

Each instruction carries its own line width: one, two or four data lines. One table can therefore describe single, dual or quad reads, or a read with a quad address phase. Received bytes leave on a valid/ready stream. The consumer may hold off by keeping ready low. While a byte waits unaccepted, the serial clock and the sequencer freeze in place, so no byte is ever dropped. The data lines leave the block as separate output, output-enable and input vectors for a pad ring to combine.

Top module: `qseq_engine`

## Requirements
- R1: An instruction holds its opcode in bits 15:10, its line-width code in bits 9:8 and its operand in bits 7:0. Table word k holds instruction 2k in bits 15:0 and instruction 2k+1 in bits 31:16.
- R2: When the engine is idle, a start pulse latches start_addr, drives cs_n low and raises busy. Execution begins at the current instruction pointer, which is 0 after reset. A start pulse while busy is high is ignored.
- R3: sclk is low whenever cs_n is high. Each sclk half period lasts CLK_DIV/2 system clocks. dq_o and dq_oe change only while sclk is low, and dq_i is sampled at the rising edge of sclk.
- R4: Opcode 1 (command) shifts out its 8-bit operand, most significant bit first.
- R5: Opcode 2 (address) shifts out the low N bits of the latched address, most significant bit first. N is the operand, capped at 32, and the address is zero-extended above bit 23.
- R6: Line-width code 0 drives line 0 and receives on line 1, with dq_oe = 0001. Code 1 uses lines 1:0 in both directions, with dq_oe = 0011. Codes 2 and 3 use lines 3:0, with dq_oe = 1111. On several lines, the highest line carries the most significant bit of each group.
- R7: Opcode 3 (dummy) runs operand sclk cycles with dq_oe = 0000. An instruction whose count works out to zero produces no sclk cycles.
- R8: Opcode 7 (read) receives operand bytes with dq_oe = 0000 and emits them on the stream in arrival order. The first bit received becomes the most significant bit of its byte.
- R9: Opcode 9 (jump) drives cs_n high and drops busy. It sets the instruction pointer to its operand, so the next start begins there.
- R10: Opcode 0 (stop) and any other unlisted opcode drive cs_n high, drop busy and reset the instruction pointer to 0.
- R11: rx_valid stays high and rx_data stays stable until rx_ready is seen high. While a byte waits unaccepted, sclk does not toggle and busy stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Instruction table write enable |
| tbl_waddr | input | $clog2(TBL_WORDS) | Table word index |
| tbl_wdata | input | 32 | Two packed instructions |
| start | input | 1 | Start pulse, honoured only when idle |
| start_addr | input | 24 | Flash address for the transaction |
| busy | output | 1 | Transaction in progress |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Consumer accepts the byte |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| dq_o | output | 4 | Data line output values |
| dq_oe | output | 4 | Per-line output enables |
| dq_i | input | 4 | Data line input values |

## Verification
The bench runs the same program under single, dual and quad reads and a quad address phase, and puts noise on lines that must be ignored. A design that mapped lines or bit order wrongly would show scrambled bytes or address nibbles. A zero-count dummy and a 32-bit address field cover the count edge cases: a design that got them wrong would add stray clocks or lose the zero-extension. Repeated starts after a jump to a non-zero index and after stop or unknown opcodes would expose an instruction pointer that is kept or reset wrongly. A consumer that holds ready low would expose a design that keeps clocking the flash and overwrites the held byte. A second start pulse mid-transaction would expose one that restarts or relatches the address.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam logic [5:0] OP_STOP  = 6'd0;
  localparam logic [5:0] OP_CMD   = 6'd1;
  localparam logic [5:0] OP_ADDR  = 6'd2;
  localparam logic [5:0] OP_DUMMY = 6'd3;
  localparam logic [5:0] OP_READ  = 6'd7;
  localparam logic [5:0] OP_JMP   = 6'd9;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] pad;
    logic [7:0] arg;
  } qseq_instr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SHIFT} qseq_state_e;

  // log2 of the number of active lines
  function automatic logic [1:0] pad_shift(input logic [1:0] pad);
    case (pad)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/qseq_lut.sv
module qseq_lut #(
  parameter int WORDS = 8,
  localparam int AW = $clog2(WORDS),
  localparam int IW = AW + 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_instr
);
  logic [31:0] mem [WORDS];
  logic [31:0] word;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign word     = mem[rd_idx[IW-1:1]];
  assign rd_instr = rd_idx[0] ? word[31:16] : word[15:0];
endmodule

// File: rtl/qseq_sclk.sv
module qseq_sclk #(
  parameter int HALF = 2,
  localparam int CW = $clog2(HALF) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic sclk,
  output logic rise,
  output logic fall
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(HALF - 1));
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3 / R11: the serial clock only moves while the divider is running
  a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(sclk));
endmodule

// File: rtl/qseq_rx.sv
module qseq_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic [1:0] wsh,
  input  logic [3:0] din,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready
);
  logic [7:0] acc, nxt;
  logic [3:0] cnt, cnt_n;

  always_comb begin
    case (wsh)
      2'd0:    nxt = {acc[6:0], din[1]};
      2'd1:    nxt = {acc[5:0], din[1:0]};
      default: nxt = {acc[3:0], din[3:0]};
    endcase
    cnt_n = cnt + (4'd1 << wsh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      cnt      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (sample) begin
        if (cnt_n == 4'd8) begin
          rx_data  <= nxt;
          rx_valid <= 1'b1;
          acc      <= '0;
          cnt      <= '0;
        end else begin
          acc <= nxt;
          cnt <= cnt_n;
        end
      end
    end
  end

  a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: rtl/qseq_engine.sv
module qseq_engine
  import qseq_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int TBL_WORDS = 8,
  localparam int TAW  = $clog2(TBL_WORDS),
  localparam int IPW  = TAW + 1,
  localparam int BW   = 12,
  localparam int HALF = CLK_DIV / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tbl_we,
  input  logic [TAW-1:0] tbl_waddr,
  input  logic [31:0]    tbl_wdata,
  input  logic           start,
  input  logic [23:0]    start_addr,
  output logic           busy,
  output logic [7:0]     rx_data,
  output logic           rx_valid,
  input  logic           rx_ready,
  output logic           sclk,
  output logic           cs_n,
  output logic [3:0]     dq_o,
  output logic [3:0]     dq_oe,
  input  logic [3:0]     dq_i
);
  qseq_state_e     state;
  logic [IPW-1:0]  ip;
  logic [23:0]     addr_q;
  logic [31:0]     shreg;
  logic [BW-1:0]   beats;
  logic [5:0]      cur_op;
  logic [1:0]      cur_wsh;
  logic            cs_q;

  logic [15:0]     lut_word;
  qseq_instr_t     ins;
  logic [1:0]      ld_wsh;
  logic [5:0]      nbits;
  logic [BW-1:0]   ld_beats;
  logic [31:0]     ld_sh;
  logic            terminal;
  logic            hold, rise, fall, drive;

  qseq_lut #(.WORDS(TBL_WORDS)) u_lut (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .rd_idx(ip), .rd_instr(lut_word)
  );

  assign hold = rx_valid && !rx_ready;

  qseq_sclk #(.HALF(HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT && !hold),
    .clear(state == ST_IDLE), .sclk(sclk), .rise(rise), .fall(fall)
  );

  qseq_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sample(rise && cur_op == OP_READ),
    .wsh(cur_wsh), .din(dq_i), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  // instruction decode at the fetch point
  assign ins    = lut_word;
  assign ld_wsh = pad_shift(ins.pad);
  assign nbits  = (ins.arg > 8'd32) ? 6'd32 : ins.arg[5:0];

  always_comb begin
    ld_beats = '0;
    ld_sh    = '0;
    terminal = 1'b0;
    case (ins.op)
      OP_CMD: begin
        ld_beats = BW'(8) >> ld_wsh;
        ld_sh    = {ins.arg, 24'h0};
      end
      OP_ADDR: begin
        ld_beats = BW'(nbits) >> ld_wsh;
        ld_sh    = {8'h0, addr_q} << (6'd32 - nbits);
      end
      OP_DUMMY: ld_beats = BW'(ins.arg);
      OP_READ:  ld_beats = BW'({ins.arg, 3'b000}) >> ld_wsh;
      default:  terminal = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ip      <= '0;
      addr_q  <= '0;
      shreg   <= '0;
      beats   <= '0;
      cur_op  <= OP_STOP;
      cur_wsh <= '0;
      cs_q    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          addr_q <= start_addr;
          cs_q   <= 1'b0;
          state  <= ST_FETCH;
        end
        ST_FETCH: if (!hold) begin
          if (terminal) begin
            state <= ST_IDLE;
            cs_q  <= 1'b1;
            ip    <= (ins.op == OP_JMP) ? ins.arg[IPW-1:0] : '0;
          end else begin
            ip <= ip + 1'b1;
            if (ld_beats != '0) begin
              state   <= ST_SHIFT;
              shreg   <= ld_sh;
              beats   <= ld_beats;
              cur_op  <= ins.op;
              cur_wsh <= ld_wsh;
            end
          end
        end
        default: if (fall) begin
          if (beats == BW'(1)) begin
            state <= ST_FETCH;
          end else begin
            beats <= beats - 1'b1;
            shreg <= shreg << (6'd1 << cur_wsh);
          end
        end
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign cs_n  = cs_q;
  assign drive = (state == ST_SHIFT) && (cur_op == OP_CMD || cur_op == OP_ADDR);

  always_comb begin
    case (cur_wsh)
      2'd0: begin dq_o = {3'b000, shreg[31]};   dq_oe = drive ? 4'b0001 : 4'b0000; end
      2'd1: begin dq_o = {2'b00, shreg[31:30]}; dq_oe = drive ? 4'b0011 : 4'b0000; end
      default: begin dq_o = shreg[31:28];       dq_oe = drive ? 4'b1111 : 4'b0000; end
    endcase
  end

  a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r3_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(dq_o) && $stable(dq_oe)));
  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  a_r2_start_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !cs_n));
  a_r11_clock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(sclk));
  a_r7_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && (cur_op == OP_DUMMY || cur_op == OP_READ)) |-> (dq_oe == 4'b0000));
endmodule

// File: tb/sim_qseq_engine.sv
module sim_qseq_engine;
  localparam int CLK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_waddr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic        sclk, cs_n;
  logic [3:0]  dq_o, dq_oe;
  logic [3:0]  dq_i = '0;

  always #5 clk = ~clk;

  qseq_engine #(.CLK_DIV(CLK_DIV), .TBL_WORDS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .start(start), .start_addr(start_addr), .busy(busy),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .sclk(sclk),
    .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int checks = 0;
  int fails = 0;
  logic [3:0]  cap_o [256];
  logic [3:0]  cap_oe[256];
  logic [3:0]  resp  [256];
  logic [7:0]  rxq   [64];
  logic [15:0] prog  [16];
  logic [7:0]  txb   [16];
  int nrise = 0;
  int ncs = 0;
  int nrx = 0;

  // flash-side model: capture at rising sclk, present data after falling sclk
  always @(posedge sclk) begin
    if (nrise < 256) begin
      cap_o[nrise]  = dq_o;
      cap_oe[nrise] = dq_oe;
    end
    nrise = nrise + 1;
  end
  always @(negedge sclk or negedge cs_n) dq_i <= (nrise < 256) ? resp[nrise] : 4'h0;
  always @(negedge cs_n) ncs = ncs + 1;
  always @(posedge clk) begin
    if (rx_valid && rx_ready && nrx < 64) begin
      rxq[nrx] = rx_data;
      nrx = nrx + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int pad, input int arg);
    return {op[5:0], pad[1:0], arg[7:0]};
  endfunction

  task automatic clr_prog();
    for (int k = 0; k < 16; k++) prog[k] = 16'h0;
    for (int k = 0; k < 256; k++) resp[k] = 4'hF;
  endtask

  task automatic load_prog();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_waddr = k[2:0]; tbl_wdata = {prog[2*k+1], prog[2*k]};
    end
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic fast_prog();
    clr_prog();
    prog[0] = 16'h040B; prog[1] = 16'h0A18; prog[2] = 16'h0C08;
    prog[3] = 16'h1E04; prog[4] = 16'h2400;
    load_prog();
  endtask

  task automatic pulse_start(input logic [23:0] a);
    @(negedge clk); nrise = 0; nrx = 0; start_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input logic [23:0] a);
    pulse_start(a);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_field(input string req, input string what, input int first,
                           input int nbits, input logic [31:0] val, input int wsh);
    int w = 1 << wsh;
    logic [3:0] msk = (wsh == 0) ? 4'h1 : (wsh == 1) ? 4'h3 : 4'hF;
    logic [31:0] got = '0;
    logic ok = 1'b1;
    for (int b = 0; b < nbits / w; b++) begin
      got = (got << w) | 32'(cap_o[first+b] & msk);
      if (cap_oe[first+b] !== msk) ok = 1'b0;
    end
    chk(req, what, got, val);
    chk(req, {what, " enables"}, 32'(ok), 32'd1);
  endtask

  task automatic chk_quiet(input string req, input int first, input int n);
    logic ok = 1'b1;
    for (int b = first; b < first + n; b++) if (cap_oe[b] !== 4'h0) ok = 1'b0;
    chk(req, "lines released", 32'(ok), 32'd1);
  endtask

  task automatic set_read(input int first, input int nbytes, input int wsh);
    int w = 1 << wsh;
    int per = 8 / w;
    for (int j = 0; j < nbytes; j++)
      for (int b = 0; b < per; b++) begin
        logic [3:0] g = 4'((txb[j] >> (8 - (b + 1) * w)) & ((1 << w) - 1));
        if (wsh == 0)      resp[first + j*per + b] = {2'b10, g[0], 1'b1};
        else if (wsh == 1) resp[first + j*per + b] = {2'b11, g[1:0]};
        else               resp[first + j*per + b] = g;
      end
  endtask

  task automatic chk_rx(input string req, input int n);
    chk(req, "byte count", 32'(nrx), 32'(n));
    for (int j = 0; j < n; j++) chk(req, "byte value", 32'(rxq[j]), 32'(txb[j]));
  endtask

  task automatic t_reset();
    chk("R2", "busy after reset", 32'(busy), 32'd0);
    chk("R3", "cs_n/sclk after reset", {30'd0, cs_n, sclk}, 32'd2);
    chk("R11", "rx_valid after reset", 32'(rx_valid), 32'd0);
    chk("R7", "enables after reset", 32'(dq_oe), 32'd0);
  endtask

  task automatic t_fast_quad();
    fast_prog();
    txb[0] = 8'hA7; txb[1] = 8'h3E; txb[2] = 8'hC1; txb[3] = 8'h90;
    set_read(22, 4, 2);
    run(24'h5A3C81);
    chk("R1", "beat count", 32'(nrise), 32'd30);
    chk_field("R4", "command", 0, 8, 32'h0B, 0);
    chk_field("R6", "quad address", 8, 24, 32'h5A3C81, 2);
    chk_quiet("R7", 14, 16);
    chk_rx("R8", 4);
    chk("R9", "cs released", {30'd0, busy, cs_n}, 32'd1);
  endtask

  task automatic t_dual();
    clr_prog();
    prog[0] = ins(1, 0, 8'h3B); prog[1] = ins(2, 0, 24); prog[2] = ins(3, 0, 8);
    prog[3] = ins(7, 1, 2);     prog[4] = ins(9, 0, 0);
    load_prog();
    txb[0] = 8'h6D; txb[1] = 8'hB2;
    set_read(40, 2, 1);
    run(24'h0F1E2D);
    chk("R6", "dual beat count", 32'(nrise), 32'd48);
    chk_field("R5", "single address", 8, 24, 32'h0F1E2D, 0);
    chk_rx("R8", 2);
  endtask

  task automatic t_single();
    clr_prog();
    prog[0] = ins(1, 0, 8'h03); prog[1] = ins(2, 0, 24);
    prog[2] = ins(7, 0, 3);     prog[3] = ins(9, 0, 0);
    load_prog();
    txb[0] = 8'h81; txb[1] = 8'h5F; txb[2] = 8'h2C;
    set_read(32, 3, 0);
    run(24'hFEDCBA);
    chk("R6", "single beat count", 32'(nrise), 32'd56);
    chk_field("R4", "read command", 0, 8, 32'h03, 0);
    chk_rx("R6", 3);
  endtask

  task automatic t_wide_addr();
    clr_prog();
    prog[0] = ins(1, 0, 8'h13); prog[1] = ins(3, 0, 0);
    prog[2] = ins(2, 0, 32);    prog[3] = ins(9, 0, 0);
    load_prog();
    run(24'hC0FFEE);
    chk("R7", "zero dummy adds no clocks", 32'(nrise), 32'd40);
    chk_field("R5", "32-bit address", 8, 32, 32'h00C0FFEE, 0);
  endtask

  task automatic t_jump();
    clr_prog();
    prog[0] = ins(1, 0, 8'h05); prog[1] = ins(9, 0, 4);
    prog[4] = ins(1, 0, 8'h06); prog[5] = ins(9, 0, 0);
    load_prog();
    run(24'h0);
    chk_field("R9", "first pass", 0, 8, 32'h05, 0);
    run(24'h0);
    chk("R9", "jump target beats", 32'(nrise), 32'd8);
    chk_field("R9", "after jump to 4", 0, 8, 32'h06, 0);
    run(24'h0);
    chk_field("R9", "after jump to 0", 0, 8, 32'h05, 0);
  endtask

  task automatic t_stop();
    clr_prog();
    prog[0] = ins(1, 0, 8'h9F);
    load_prog();
    run(24'h0);
    run(24'h0);
    chk("R10", "stop beats", 32'(nrise), 32'd8);
    chk_field("R10", "stop restarts at 0", 0, 8, 32'h9F, 0);
    clr_prog();
    prog[0] = ins(1, 0, 8'hAB); prog[1] = ins(6'h3F, 0, 5);
    prog[2] = ins(1, 0, 8'h11); prog[5] = ins(1, 0, 8'h22);
    load_prog();
    run(24'h0);
    chk("R10", "unknown opcode ends", {29'd0, busy, cs_n, 1'(nrise == 8)}, 32'd3);
    run(24'h0);
    chk_field("R10", "unknown opcode restarts at 0", 0, 8, 32'hAB, 0);
  endtask

  task automatic t_busy_start();
    int c0;
    fast_prog();
    c0 = ncs;
    pulse_start(24'h123456);
    repeat (20) @(negedge clk);
    start_addr = 24'h654321; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2", "one select per start", 32'(ncs - c0), 32'd1);
    chk_field("R2", "address unchanged", 8, 24, 32'h123456, 2);
    chk("R2", "no extra beats", 32'(nrise), 32'd30);
  endtask

  task automatic t_divider();
    int n = 0;
    fast_prog();
    pulse_start(24'h000111);
    @(posedge sclk);
    while (sclk) begin @(posedge clk); #1; n++; end
    chk("R3", "sclk high length", 32'(n), 32'(CLK_DIV / 2));
    n = 0;
    while (!sclk) begin @(posedge clk); #1; n++; end
    chk("R3", "sclk low length", 32'(n), 32'(CLK_DIV / 2));
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_backpressure();
    int n0;
    logic [7:0] d0;
    fast_prog();
    txb[0] = 8'h1D; txb[1] = 8'hE2; txb[2] = 8'h47; txb[3] = 8'hB8;
    set_read(22, 4, 2);
    rx_ready = 1'b0;
    pulse_start(24'hABCDEF);
    for (int j = 0; j < 4; j++) begin
      while (!rx_valid) @(negedge clk);
      n0 = nrise; d0 = rx_data;
      repeat (12) @(negedge clk);
      chk("R11", "clock frozen while held", 32'(nrise), 32'(n0));
      chk("R11", "held byte stable", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, d0});
      chk("R11", "busy while held", 32'(busy), 32'd1);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
    while (busy) @(negedge clk);
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk_rx("R11", 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=hung expected=idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clr_prog();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_fast_quad();
    t_dual();
    t_single();
    t_wide_addr();
    t_jump();
    t_stop();
    t_busy_start();
    t_divider();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule